// File: doc/BRIEF.md
# Boost Switching Mode Controller

This block sequences the two power switches of a synchronous boost stage once per oscillator period and decides, from what the inductor current and the output comparators report, whether each period runs as a fixed-frequency pulse-width cycle or as a light-load pulse-skipping cycle. All inputs are single-bit flags sampled on the system clock `clk`. `osc_tick` is a one-clock pulse that marks the start of each switching period.

In PWM mode each period begins with a non-overlap gap and then the high-side switch. When the PWM comparator trips, the high-side switch turns off. After a second gap the low-side switch conducts until the next tick. The block moves to PFM after a run of periods in which the inductor current reached zero. In PFM each tick fires one low-side pulse, which ends at the valley flag. The high-side switch then drains the inductor down to zero current.

An output that sits above its upper band cuts the pulse short and holds off new pulses. An output below its lower band returns the block to PWM. A run of periods that all hit the current limit latches an overcurrent fault, which holds both switches off until reset.

Top module: `boost_sw_ctrl`

## Requirements
- R1: `hi_gate` and `lo_gate` are never high in the same clock. While `rst` is high and in the clock after it, both gates, `sw_strobe` and `oc_fault` read 0, and the controller is in PWM mode.
- R2: In PWM mode, a clock with `osc_tick`=1 drives both gates to 0 from the next clock on, unless the high side is on, in which case it stays on. Both gates stay at 0 for DEAD_CYC clocks, after which `hi_gate` rises.
- R3: In PWM mode, `pwm_trip`=1 while the high side is on (in a clock with no tick) turns the high side off. After DEAD_CYC clocks with both gates at 0, `lo_gate` rises and stays high until the next tick.
- R4: Each period runs from one tick up to and including the next tick. A period counts when `zero_cross` was 1 in at least one of its clocks. When ZC_RUN (8) consecutive periods count, PFM mode starts from the next tick. A period that does not count resets the run.
- R5: In PFM mode, a tick with the switches idle raises `lo_gate` in the next clock, with no gap. `valley_low`=1 ends the low-side pulse, and `hi_gate` rises after DEAD_CYC clocks. `zero_cross`=1 then turns both gates off until the next tick.
- R6: In PFM mode, `vout_hi`=1 ends a low-side pulse at once, just as the valley flag does. While `vout_hi` is 1, ticks start no new pulse.
- R7: In PFM mode, `vout_lo`=1 returns the controller to PWM mode from the next clock, and the zero-cross run restarts from zero.
- R8: When LIM_RUN (16) consecutive periods each see `ilim_hit`=1 in at least one clock, `oc_fault` rises and both gates go to 0 in the clock after the closing tick. Both stay that way until reset. A period without a limit hit resets the run.
- R9: `sw_strobe` is a one-clock pulse that is high exactly in the first clock of each low-side on-interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-clock pulse starting a switching period |
| pwm_trip | input | 1 | PWM comparator trip |
| zero_cross | input | 1 | Inductor current reached zero |
| valley_low | input | 1 | Inductor current at the PFM valley threshold |
| ilim_hit | input | 1 | Current limit reached |
| vout_hi | input | 1 | Output above upper band |
| vout_lo | input | 1 | Output below lower band |
| lo_gate | output | 1 | Low-side switch enable |
| hi_gate | output | 1 | High-side switch enable |
| sw_strobe | output | 1 | Low-side turn-on strobe |
| oc_fault | output | 1 | Latched overcurrent fault |

## Verification
The bench targets the boundaries of both runs. It sends seven zero-cross periods, a break and then a full run. It also sends a limit run that is broken once before it completes. A design that counted without resetting would enter PFM or latch the fault one run early. A design that compared against the wrong terminal count would switch one period late or early.

Ticks that land in the middle of a dead gap or during a high-side drain check that the gap is always inserted. A missed gap would show overlap or a zero-length gap before the high side. An upper band that is held high checks that pulses are cut short and skipped. An exit through the lower band checks the return to PWM, where a design that kept its PFM state would start the next period with the low side instead of a gap.

// File: rtl/boost_sw_pkg.sv
package boost_sw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HS   = 3'd1,
    ST_GAPL = 3'd2,
    ST_LS   = 3'd3,
    ST_GAPH = 3'd4
  } sw_state_t;
endpackage

// File: rtl/swmode_tracker.sv
module swmode_tracker #(
  parameter int ZC_RUN  = 8,
  parameter int LIM_RUN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  input  logic zero_cross,
  input  logic ilim_hit,
  input  logic vout_lo,
  output logic pfm_mode,
  output logic fault_q,
  output logic fault_set
);
  localparam int ZW = $clog2(ZC_RUN + 1);
  localparam int LW = $clog2(LIM_RUN + 1);
  localparam logic [ZW-1:0] ZC_LAST  = ZW'(ZC_RUN - 1);
  localparam logic [LW-1:0] LIM_LAST = LW'(LIM_RUN - 1);

  logic          zc_seen, lim_seen;
  logic [ZW-1:0] zc_cnt;
  logic [LW-1:0] lim_cnt;
  logic          zc_hit, lim_hit_per;

  assign zc_hit      = zc_seen | zero_cross;
  assign lim_hit_per = lim_seen | ilim_hit;
  assign fault_set   = osc_tick & lim_hit_per & (lim_cnt == LIM_LAST) & ~fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      zc_seen  <= 1'b0;
      lim_seen <= 1'b0;
      lim_cnt  <= '0;
      fault_q  <= 1'b0;
    end else begin
      if (osc_tick) begin
        zc_seen  <= 1'b0;
        lim_seen <= 1'b0;
        if (!lim_hit_per)            lim_cnt <= '0;
        else if (lim_cnt != LIM_LAST) lim_cnt <= lim_cnt + 1'b1;
      end else begin
        zc_seen  <= zc_hit;
        lim_seen <= lim_hit_per;
      end
      if (fault_set) fault_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfm_mode <= 1'b0;
      zc_cnt   <= '0;
    end else if (pfm_mode && vout_lo) begin
      pfm_mode <= 1'b0;
      zc_cnt   <= '0;
    end else if (osc_tick) begin
      if (pfm_mode || !zc_hit) begin
        zc_cnt <= '0;
      end else if (zc_cnt == ZC_LAST) begin
        pfm_mode <= 1'b1;
        zc_cnt   <= '0;
      end else begin
        zc_cnt <= zc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swgate_seq.sv
module swgate_seq
  import boost_sw_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pfm_mode,
  input  logic kill,
  input  logic osc_tick,
  input  logic pwm_trip,
  input  logic zero_cross,
  input  logic valley_low,
  input  logic vout_hi,
  output logic hi_gate,
  output logic lo_gate,
  output logic sw_strobe
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] GAP_LOAD = DW'(DEAD_CYC - 1);

  sw_state_t     st, st_n;
  logic [DW-1:0] gap, gap_n;

  always_comb begin
    st_n  = st;
    gap_n = gap;
    if (kill) begin
      st_n  = ST_IDLE;
      gap_n = '0;
    end else if (osc_tick && !pfm_mode) begin
      if (st != ST_HS) begin
        st_n  = ST_GAPH;
        gap_n = GAP_LOAD;
      end
    end else if (osc_tick && pfm_mode && !vout_hi) begin
      case (st)
        ST_IDLE: st_n = ST_LS;
        ST_LS:   st_n = ST_LS;
        default: begin
          st_n  = ST_GAPL;
          gap_n = GAP_LOAD;
        end
      endcase
    end else begin
      case (st)
        ST_GAPH: if (gap == '0) st_n = ST_HS; else gap_n = gap - 1'b1;
        ST_GAPL: if (gap == '0) st_n = ST_LS; else gap_n = gap - 1'b1;
        ST_HS: begin
          if (!pfm_mode && pwm_trip) begin
            st_n  = ST_GAPL;
            gap_n = GAP_LOAD;
          end else if (pfm_mode && zero_cross) begin
            st_n = ST_IDLE;
          end
        end
        ST_LS: begin
          if (pfm_mode && (valley_low || vout_hi)) begin
            st_n  = ST_GAPH;
            gap_n = GAP_LOAD;
          end
        end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      gap       <= '0;
      hi_gate   <= 1'b0;
      lo_gate   <= 1'b0;
      sw_strobe <= 1'b0;
    end else begin
      st        <= st_n;
      gap       <= gap_n;
      hi_gate   <= (st_n == ST_HS);
      lo_gate   <= (st_n == ST_LS);
      sw_strobe <= (st_n == ST_LS) && (st != ST_LS);
    end
  end
endmodule

// File: rtl/boost_sw_ctrl.sv
module boost_sw_ctrl #(
  parameter int DEAD_CYC = 2,
  parameter int ZC_RUN   = 8,
  parameter int LIM_RUN  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  input  logic pwm_trip,
  input  logic zero_cross,
  input  logic valley_low,
  input  logic ilim_hit,
  input  logic vout_hi,
  input  logic vout_lo,
  output logic lo_gate,
  output logic hi_gate,
  output logic sw_strobe,
  output logic oc_fault
);
  logic pfm_mode, fault_q, fault_set;

  swmode_tracker #(.ZC_RUN(ZC_RUN), .LIM_RUN(LIM_RUN)) u_trk (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .zero_cross(zero_cross),
    .ilim_hit(ilim_hit), .vout_lo(vout_lo), .pfm_mode(pfm_mode),
    .fault_q(fault_q), .fault_set(fault_set)
  );

  swgate_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst(rst), .pfm_mode(pfm_mode), .kill(fault_q | fault_set),
    .osc_tick(osc_tick), .pwm_trip(pwm_trip), .zero_cross(zero_cross),
    .valley_low(valley_low), .vout_hi(vout_hi),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .sw_strobe(sw_strobe)
  );

  assign oc_fault = fault_q;
endmodule

// File: rtl/boost_sw_ctrl_chk.sv
module boost_sw_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hi_gate,
  input logic lo_gate,
  input logic sw_strobe,
  input logic oc_fault
);
  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_gate && lo_gate));
  // R2
  hi_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_gate) |-> !$past(lo_gate));
  // R3
  lo_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_gate) |-> !$past(hi_gate));
  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    oc_fault |=> oc_fault);
  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    oc_fault |-> (!hi_gate && !lo_gate));
  // R9
  strobe_on_lo_chk: assert property (@(posedge clk) disable iff (rst)
    sw_strobe |-> lo_gate);
endmodule

bind boost_sw_ctrl boost_sw_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .hi_gate(hi_gate), .lo_gate(lo_gate),
  .sw_strobe(sw_strobe), .oc_fault(oc_fault)
);

// File: tb/sim_boost_sw_ctrl.sv
module sim_boost_sw_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DT  = 2;
  localparam int ZCR = 8;
  localparam int LMR = 16;

  logic clk = 0, rst = 1;
  logic osc_tick = 0, pwm_trip = 0, zero_cross = 0, valley_low = 0;
  logic ilim_hit = 0, vout_hi = 0, vout_lo = 0;
  logic lo_gate, hi_gate, sw_strobe, oc_fault;

  int checks = 0, errors = 0;
  int p_trip = 0, p_zc = 0, p_val = 0, p_lim = 0, p_hi = 0, p_lo = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_sw_ctrl #(.DEAD_CYC(DT), .ZC_RUN(ZCR), .LIM_RUN(LMR)) u0 (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .pwm_trip(pwm_trip),
    .zero_cross(zero_cross), .valley_low(valley_low), .ilim_hit(ilim_hit),
    .vout_hi(vout_hi), .vout_lo(vout_lo), .lo_gate(lo_gate),
    .hi_gate(hi_gate), .sw_strobe(sw_strobe), .oc_fault(oc_fault)
  );

  // Reference model built from the requirements. States: 0 idle, 1 high,
  // 2 gap before low, 3 low, 4 gap before high.
  int m_st = 0, m_gap = 0, m_zcc = 0, m_lmc = 0;
  bit m_pfm = 0, m_flt = 0, m_zcs = 0, m_lms = 0;
  bit e_hi = 0, e_lo = 0, e_sb = 0;

  function automatic int fsm_next(int st, bit pfm, bit kill, ref int gap);
    int n = st;
    if (kill) begin n = 0; gap = 0; end
    else if (osc_tick && !pfm) begin
      if (st != 1) begin n = 4; gap = DT - 1; end           // R2
    end else if (osc_tick && pfm && !vout_hi) begin
      if (st == 0) n = 3;                                   // R5
      else if (st != 3) begin n = 2; gap = DT - 1; end
    end else begin
      case (st)
        4: if (gap == 0) n = 1; else gap = gap - 1;
        2: if (gap == 0) n = 3; else gap = gap - 1;
        1: if (!pfm && pwm_trip) begin n = 2; gap = DT - 1; end  // R3
           else if (pfm && zero_cross) n = 0;
        3: if (pfm && (valley_low || vout_hi)) begin n = 4; gap = DT - 1; end  // R6
        default: n = st;
      endcase
    end
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_gap = 0; m_zcc = 0; m_lmc = 0; m_pfm = 0; m_flt = 0;
      m_zcs = 0; m_lms = 0; e_hi = 0; e_lo = 0; e_sb = 0;
    end else begin
      bit zh, lh, trip;
      int n;
      zh = m_zcs | zero_cross;
      lh = m_lms | ilim_hit;
      trip = osc_tick && lh && (m_lmc == LMR - 1) && !m_flt;   // R8
      n = fsm_next(m_st, m_pfm, m_flt | trip, m_gap);
      e_hi = (n == 1); e_lo = (n == 3); e_sb = (n == 3) && (m_st != 3);
      m_st = n;
      if (osc_tick) begin
        m_zcs = 0; m_lms = 0;
        if (!lh) m_lmc = 0; else if (m_lmc != LMR - 1) m_lmc++;
      end else begin
        m_zcs = zh; m_lms = lh;
      end
      if (trip) m_flt = 1;
      if (m_pfm && vout_lo) begin m_pfm = 0; m_zcc = 0; end     // R7
      else if (osc_tick) begin                                  // R4
        if (m_pfm || !zh) m_zcc = 0;
        else if (m_zcc == ZCR - 1) begin m_pfm = 1; m_zcc = 0; end
        else m_zcc++;
      end
    end
  end

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1", "gate overlap", int'(hi_gate && lo_gate), 0);
    chk(tag, "hi_gate", int'(hi_gate), int'(e_hi));
    chk(tag, "lo_gate", int'(lo_gate), int'(e_lo));
    chk("R9", "sw_strobe", int'(sw_strobe), int'(e_sb));
    chk("R8", "oc_fault", int'(oc_fault), int'(m_flt));
  endtask

  task automatic run_period(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      compare();
      osc_tick   = (i == 0);
      pwm_trip   = pct(p_trip);
      zero_cross = (i != 0) && pct(p_zc);
      valley_low = pct(p_val);
      ilim_hit   = (i != 0) && pct(p_lim);
      vout_hi    = pct(p_hi);
      vout_lo    = pct(p_lo);
    end
  endtask

  task automatic run_many(int n);
    for (int k = 0; k < n; k++) run_period(12 + ($urandom % 9));
  endtask

  task automatic knobs(int t, int z, int v, int l, int h, int o);
    p_trip = t; p_zc = z; p_val = v; p_lim = l; p_hi = h; p_lo = o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; osc_tick = 0; pwm_trip = 0; zero_cross = 0; valley_low = 0;
    ilim_hit = 0; vout_hi = 0; vout_lo = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset hi", int'(hi_gate), 0);
    chk("R1", "reset lo", int'(lo_gate), 0);
    chk("R1", "reset strobe", int'(sw_strobe), 0);
    chk("R1", "reset fault", int'(oc_fault), 0);
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0b05));
    tag = "R1";
    do_reset();
    // R2: ticks only, high side held for whole period
    tag = "R2"; knobs(0, 0, 0, 0, 0, 0); run_many(4);
    // R3: comparator trips inside the period
    tag = "R3"; knobs(12, 0, 0, 0, 0, 0); run_many(10);
    // R4: seven counted periods, one miss, then a full run
    tag = "R4"; knobs(12, 100, 0, 0, 0, 0); run_many(7);
    knobs(12, 0, 0, 0, 0, 0); run_many(1);
    knobs(12, 100, 0, 0, 0, 0); run_many(7);
    @(negedge clk); chk("R4", "still PWM after 7", int'(m_pfm), 0);
    run_many(3);
    chk("R4", "mode after full run (model)", int'(m_pfm), 1);
    // R5: PFM pulses
    tag = "R5"; knobs(5, 20, 20, 0, 0, 0); run_many(10);
    // R6: output high band cuts and skips pulses
    tag = "R6"; knobs(5, 20, 5, 0, 40, 0); run_many(10);
    knobs(5, 20, 5, 0, 100, 0); run_many(3);
    // R7: low band returns to PWM
    tag = "R7"; knobs(10, 20, 20, 0, 0, 8); run_many(12);
    // mixed random traffic
    tag = "R3"; knobs(10, 30, 20, 0, 5, 2); run_many(40);
    // R8: limit run with a break, then a full run
    tag = "R8";
    do_reset();
    knobs(10, 0, 0, 100, 0, 0); run_many(10);
    knobs(10, 0, 0, 0, 0, 0); run_many(1);
    knobs(10, 0, 0, 100, 0, 0); run_many(15);
    chk("R8", "no fault after broken run", int'(oc_fault), 0);
    run_many(3);
    chk("R8", "fault latched", int'(oc_fault), 1);
    chk("R8", "gates off", int'(hi_gate | lo_gate), 0);
    knobs(30, 30, 30, 0, 0, 0); run_many(3);
    chk("R8", "fault held", int'(oc_fault), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired before the run completed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule